// File: doc/BRIEF.md
# Radix-4 Word-Serial Montgomery Multiplier Kernel

This block computes a Montgomery product X·Y·4^-L mod M, where L is the number of radix-4 loops the kernel runs. Each loop takes two bits of the multiplier X. These two bits, together with the bit below them, are recoded into a signed digit in {-2,-1,0,+1,+2}, so only shifted or complemented copies of Y are ever added. A single word processor then walks the words of Y, M and the partial sum S, one BPW-bit word per clock. In the first word of each loop it picks a modulus multiple qM in {-1,0,+1,+2}. The choice depends only on the low two bits of the running sum and of M, and it clears those two bits so that the following 2-bit right shift drops nothing.

Negative digits can make the partial sum negative. The sum is therefore kept in two's complement, with two guard bits above the operand width, and the top word is sign-extended each time it is rewritten. After the last loop a single correction pass brings the value into [0, M).

A caller presents X, Y and an odd modulus M together with a one-cycle start. It then waits for the one-cycle done pulse and reads the result, which stays steady until the next done.

Top module: `mm4_kernel`

## Requirements
- R1: After reset, busy, done and result are all 0.
- R2: A start seen while busy is 0 latches x_in, y_in and m_in, and busy reads 1 in the following cycle.
- R3: The loop digit is -2·x[2i+1] + x[2i] + x[2i-1], with x[-1] = 0 and zero bits above bit N-1. The triplet codes map as follows: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, 101 and 110 give -1.
- R4: In the first word of every loop, qM is chosen from the low pair s of (S + digit·Y) and the low pair m of M: s=00 gives 0, s=10 gives +2, odd s equal to m gives -1, and any other odd s gives +1. After qM·M is added, bits 1..0 of that word are 00.
- R5: done is a one-cycle pulse raised exactly L·NW+1 clock edges after the edge that accepted start. Here L = ceil((N+2)/2) and NW = ceil((N+4)/BPW).
- R6: result equals X·Y·4^-L mod M for any X < 2^N, any Y < M and any odd M with 2^(N-1) < M < 2^N.
- R7: A start that arrives while busy is 1 is ignored. The running operation keeps its operands and timing, and no extra done is produced.
- R8: Between loops, the stored partial sum stays in (-2^(N+1), 2^(N+1)), even when negative digits drive it below zero.
- R9: Whenever done is 1, result is less than M.
- R10: If X or Y is zero, the result is zero.
- R11: A start presented in the same cycle as done begins a new operation at once. That cycle's result still belongs to the earlier operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; honoured only while idle |
| x_in | input | N | Multiplier X |
| y_in | input | N | Multiplicand Y, less than M |
| m_in | input | N | Odd modulus M with top bit set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | N | X·Y·4^-L mod M, held until the next done |

## Verification
The end of one operation and the launch of the next can share a single cycle. done is high, the kernel has returned to idle, and a fresh start is sampled on the same edge. The bench provokes this by raising start at the very negative edge on which it sees done. It then judges the first result against its scoreboard entry in that cycle, and checks that busy is back up one cycle later and that the second result arrives with full latency and the correct value. A start pulsed in the middle of a run is also judged: the earlier result must be unaffected and no surplus done may appear.

// File: rtl/mm4_pkg.sv
package mm4_pkg;

  // Selected multiple: magnitude 0, 1 or 2, and a negate flag.
  typedef struct packed {
    logic [1:0] mag;
    logic       neg;
  } mult_sel_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} kstate_t;

  // Signed digit from {x_hi, x_lo, x_below}: -2*hi + lo + below.
  function automatic mult_sel_t booth_sel(input logic [2:0] trip);
    mult_sel_t r;
    case (trip)
      3'b001, 3'b010: r = '{mag: 2'd1, neg: 1'b0};
      3'b011:         r = '{mag: 2'd2, neg: 1'b0};
      3'b100:         r = '{mag: 2'd2, neg: 1'b1};
      3'b101, 3'b110: r = '{mag: 2'd1, neg: 1'b1};
      default:        r = '{mag: 2'd0, neg: 1'b0};
    endcase
    return r;
  endfunction

  // Modulus multiple that clears the two low bits (M is odd).
  function automatic mult_sel_t quot_sel(input logic [1:0] s_lo,
                                         input logic [1:0] m_lo);
    mult_sel_t r;
    if (!s_lo[0]) begin
      if (s_lo[1]) r = '{mag: 2'd2, neg: 1'b0};
      else         r = '{mag: 2'd0, neg: 1'b0};
    end else if (s_lo == m_lo) begin
      r = '{mag: 2'd1, neg: 1'b1};
    end else begin
      r = '{mag: 2'd1, neg: 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/mm4_booth_recoder.sv
module mm4_booth_recoder
  import mm4_pkg::*;
(
  input  logic [2:0] trip,
  output mult_sel_t  sel
);
  always_comb sel = booth_sel(trip);
endmodule

// File: rtl/mm4_quot_sel.sv
module mm4_quot_sel
  import mm4_pkg::*;
(
  input  logic [1:0] s_low,
  input  logic [1:0] m_low,
  output mult_sel_t  sel
);
  always_comb sel = quot_sel(s_low, m_low);
endmodule

// File: rtl/mm4_word_pe.sv
// One word of S + qY*Y + qM*M with two inter-word carries.
module mm4_word_pe
  import mm4_pkg::*;
#(
  parameter int BPW = 8
) (
  input  logic [BPW-1:0] s_word,
  input  logic [BPW-1:0] y1_word,
  input  logic [BPW-1:0] y2_word,
  input  logic [BPW-1:0] m1_word,
  input  logic [BPW-1:0] m2_word,
  input  mult_sel_t      ysel,
  input  mult_sel_t      msel,
  input  logic           ca_in,
  input  logic           cb_in,
  output logic [1:0]     t_low,
  output logic [BPW-1:0] u_word,
  output logic           ca_out,
  output logic           cb_out
);

  function automatic logic [BPW-1:0] pick(input logic [BPW-1:0] w1,
                                          input logic [BPW-1:0] w2,
                                          input mult_sel_t sel);
    logic [BPW-1:0] b;
    case (sel.mag)
      2'd0:    b = '0;
      2'd1:    b = w1;
      default: b = w2;
    endcase
    return sel.neg ? ~b : b;
  endfunction

  logic [BPW-1:0] yterm, mterm;
  logic [BPW:0]   t_sum, u_sum;

  always_comb begin
    yterm  = pick(y1_word, y2_word, ysel);
    mterm  = pick(m1_word, m2_word, msel);
    t_sum  = {1'b0, s_word} + {1'b0, yterm} + {{BPW{1'b0}}, ca_in};
    u_sum  = {1'b0, t_sum[BPW-1:0]} + {1'b0, mterm} + {{BPW{1'b0}}, cb_in};
    t_low  = t_sum[1:0];
    u_word = u_sum[BPW-1:0];
    ca_out = t_sum[BPW];
    cb_out = u_sum[BPW];
  end

endmodule

// File: rtl/mm4_kernel.sv
module mm4_kernel
  import mm4_pkg::*;
#(
  parameter int N   = 32,
  parameter int BPW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic [N-1:0] m_in,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);

  localparam int NW    = (N + 4 + BPW - 1) / BPW;
  localparam int WT    = NW * BPW;
  localparam int LOOPS = (N + 3) / 2;
  localparam int WIW   = (NW > 1) ? $clog2(NW) : 1;
  localparam int LCW   = $clog2(LOOPS + 1);
  localparam logic [WIW-1:0] LAST_W = WIW'(NW - 1);
  localparam logic [LCW-1:0] LAST_L = LCW'(LOOPS - 1);

  kstate_t        state;
  logic [N-1:0]   x_q, y_q, m_q;
  logic           xprev;
  logic [WIW-1:0] widx;
  logic [LCW-1:0] lcnt;
  logic           ca_q, cb_q;
  mult_sel_t      qm_q;
  logic [BPW-3:0] u_hi_q;
  logic [BPW-1:0] s_w [NW];

  logic [WT-1:0]  y_ext, m_ext, s_full;
  logic [WT:0]    y2_ext, m2_ext;
  logic [BPW-1:0] y1_w [NW];
  logic [BPW-1:0] y2_w [NW];
  logic [BPW-1:0] m1_w [NW];
  logic [BPW-1:0] m2_w [NW];

  assign y_ext  = {{(WT-N){1'b0}}, y_q};
  assign m_ext  = {{(WT-N){1'b0}}, m_q};
  assign y2_ext = {y_ext, 1'b0};
  assign m2_ext = {m_ext, 1'b0};

  for (genvar k = 0; k < NW; k++) begin : g_words
    assign y1_w[k] = y_ext[k*BPW +: BPW];
    assign y2_w[k] = y2_ext[k*BPW +: BPW];
    assign m1_w[k] = m_ext[k*BPW +: BPW];
    assign m2_w[k] = m2_ext[k*BPW +: BPW];
    assign s_full[k*BPW +: BPW] = s_w[k];
  end

  // Named internal events
  logic      scanning, first_word, last_word, last_loop;
  mult_sel_t ysel, qm_now, qm_use;
  logic      ca_use, cb_use, ca_out, cb_out;
  logic [1:0]     t_low;
  logic [BPW-1:0] u_word;

  assign scanning   = (state == ST_SCAN);
  assign first_word = (widx == '0);
  assign last_word  = (widx == LAST_W);
  assign last_loop  = (lcnt == LAST_L);

  mm4_booth_recoder u_rec (
    .trip ({x_q[1], x_q[0], xprev}),
    .sel  (ysel)
  );

  mm4_quot_sel u_qsel (
    .s_low (t_low),
    .m_low (m_q[1:0]),
    .sel   (qm_now)
  );

  assign qm_use = first_word ? qm_now   : qm_q;
  assign ca_use = first_word ? ysel.neg : ca_q;
  assign cb_use = first_word ? qm_now.neg : cb_q;

  mm4_word_pe #(.BPW(BPW)) u_pe (
    .s_word  (s_w[widx]),
    .y1_word (y1_w[widx]),
    .y2_word (y2_w[widx]),
    .m1_word (m1_w[widx]),
    .m2_word (m2_w[widx]),
    .ysel    (ysel),
    .msel    (qm_use),
    .ca_in   (ca_use),
    .cb_in   (cb_use),
    .t_low   (t_low),
    .u_word  (u_word),
    .ca_out  (ca_out),
    .cb_out  (cb_out)
  );

  // Bring a sum in (-M, 2M) into [0, M).
  function automatic logic [N-1:0] final_fix(input logic [WT-1:0] s,
                                             input logic [WT-1:0] m);
    logic [WT-1:0] r;
    if (s[WT-1])     r = s + m;
    else if (s >= m) r = s - m;
    else             r = s;
    return r[N-1:0];
  endfunction

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      m_q    <= '0;
      xprev  <= 1'b0;
      widx   <= '0;
      lcnt   <= '0;
      ca_q   <= 1'b0;
      cb_q   <= 1'b0;
      qm_q   <= '0;
      u_hi_q <= '0;
      done   <= 1'b0;
      result <= '0;
      for (int k = 0; k < NW; k++) s_w[k] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            x_q   <= x_in;
            y_q   <= y_in;
            m_q   <= m_in;
            xprev <= 1'b0;
            widx  <= '0;
            lcnt  <= '0;
            for (int k = 0; k < NW; k++) s_w[k] <= '0;
            state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          ca_q   <= ca_out;
          cb_q   <= cb_out;
          u_hi_q <= u_word[BPW-1:2];
          if (first_word) qm_q <= qm_now;
          if (!first_word) s_w[widx - 1'b1] <= {u_word[1:0], u_hi_q};
          if (last_word) begin
            s_w[NW-1] <= {{2{u_word[BPW-1]}}, u_word[BPW-1:2]};
            widx  <= '0;
            x_q   <= x_q >> 2;
            xprev <= x_q[1];
            lcnt  <= lcnt + 1'b1;
            if (last_loop) state <= ST_FIN;
          end else begin
            widx <= widx + 1'b1;
          end
        end
        ST_FIN: begin
          result <= final_fix(s_full, m_ext);
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an idle start is taken
  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy)
    else $error("start not accepted");

  // R4: quotient choice clears the two low bits of the first word
  assert_low_pair_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && first_word) |-> (u_word[1:0] == 2'b00))
    else $error("low bits not cleared");

  // R5: done lasts one cycle and arrives with busy low
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!$past(done) && !busy))
    else $error("done not a single pulse");

  // R7: operands stay fixed for the whole run
  assert_operands_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(m_q) && $stable(y_q)))
    else $error("operands changed while busy");

  // R8: stored sum stays within (-2^(N+1), 2^(N+1)) between loops
  assert_sum_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && first_word) |->
      ((&s_full[WT-1:N+1]) || !(|s_full[WT-1:N+1])))
    else $error("partial sum out of range");

  // R9: reduced result below the modulus
  assert_result_below_mod_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < m_q))
    else $error("result not reduced");

endmodule

// File: tb/mm4_kernel_tb.sv
module mm4_kernel_tb;
  localparam int N     = 32;
  localparam int BPW   = 8;
  localparam int NW    = (N + 4 + BPW - 1) / BPW;
  localparam int LOOPS = (N + 3) / 2;
  localparam int LAT   = LOOPS * NW + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] x_in = '0, y_in = '0, m_in = '0;
  logic         busy, done;
  logic [N-1:0] result;

  always #2ns clk = ~clk;

  mm4_kernel #(.N(N), .BPW(BPW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .m_in(m_in),
    .busy(busy), .done(done), .result(result)
  );

  typedef struct {
    logic [N-1:0] exp;
    logic [N-1:0] m;
    longint       t0;
    string        req;
  } item_t;

  item_t  sb[$];
  longint cyc = 0;
  int     n_cmp = 0, n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Independent model: X*Y mod M, then halve mod M 2*L times.
  function automatic logic [N-1:0] model(input logic [N-1:0] x,
                                         input logic [N-1:0] y,
                                         input logic [N-1:0] m);
    logic [2*N-1:0] p;
    logic [N:0]     r;
    p = {{N{1'b0}}, x} * {{N{1'b0}}, y};
    r = (N+1)'(p % {{N{1'b0}}, m});
    for (int i = 0; i < 2 * LOOPS; i++)
      r = r[0] ? ((r + {1'b0, m}) >> 1) : (r >> 1);
    return r[N-1:0];
  endfunction

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Monitor: pop and compare at each done
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7 unexpected done", 64'(result), 64'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(result == it.exp, {it.req, " R6 value"}, 64'(result), 64'(it.exp));
        chk(cyc - it.t0 == LAT, {it.req, " R5 latency"}, 64'(cyc - it.t0), 64'(LAT));
        chk(result < it.m, {it.req, " R9 below M"}, 64'(result), 64'(it.m));
      end
    end
  end

  // Driver: called at a negative edge
  task automatic launch(input logic [N-1:0] x, input logic [N-1:0] y,
                        input logic [N-1:0] m, input string req);
    item_t it;
    x_in  = x;
    y_in  = y;
    m_in  = m;
    start = 1'b1;
    it.exp = model(x, y, m);
    it.m   = m;
    it.t0  = cyc + 1;
    it.req = req;
    sb.push_back(it);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {req, " R2 busy after start"}, 64'(busy), 64'd1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [N-1:0] x, input logic [N-1:0] y,
                     input logic [N-1:0] m, input string req);
    launch(x, y, m, req);
    wait_idle();
  endtask

  function automatic logic [N-1:0] rand_mod();
    logic [N-1:0] v;
    v = nxt();
    return {1'b1, v[N-2:1], 1'b1};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R5 watchdog", 64'd0, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] m, y;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0,   "R1 busy", 64'(busy), 64'd0);
    chk(done == 1'b0,   "R1 done", 64'(done), 64'd0);
    chk(result == '0,   "R1 result", 64'(result), 64'd0);

    m = 32'hC000_0013;
    run(32'd13, 32'h1234_5677, m, "R3 small X");
    run(32'hFFFF_FFFF, m - 1, m, "R8 all ones X");
    run(32'hAAAA_AAAA, 32'h8765_4321, m, "R3 alternating X");
    run(32'h5555_5555, 32'h0F0F_0F0F, m, "R3 alternating X2");
    run(32'h0, 32'h7777_7777, m, "R10 zero X");
    chk(result == '0, "R10 zero X result", 64'(result), 64'd0);
    run(32'h9ABC_DEF0, 32'h0, m, "R10 zero Y");
    chk(result == '0, "R10 zero Y result", 64'(result), 64'd0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R6 largest M");
    run(32'hCCCC_CCCC, 32'h8000_0000, 32'h8000_0001, "R6 smallest M");
    run(32'h8000_0000, 32'h1, 32'h8000_0001, "R4 single top bit");

    for (int i = 0; i < 8; i++) begin
      m = rand_mod();
      y = nxt() % m;
      run(nxt(), y, m, "R6 random");
    end

    // R11: new start in the cycle done is high
    m = rand_mod();
    launch(32'h1357_9BDF, 32'h2468_ACE0 % m, m, "R11 first");
    while (!done) @(negedge clk);
    launch(32'hFEDC_BA98, 32'h0123_4567 % m, m, "R11 second");
    wait_idle();

    // R7: start while busy is ignored
    m = rand_mod();
    launch(32'hDEAD_BEEF, 32'h0BAD_F00D % m, m, "R7 run");
    repeat (10) @(negedge clk);
    x_in  = 32'h1111_1111;
    y_in  = 32'h2222_2222;
    m_in  = 32'h8888_8889;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 still busy", 64'(busy), 64'd1);
    wait_idle();
    repeat (LAT + 10) @(negedge clk);
    chk(sb.size() == 0, "R7 no pending items", 64'(sb.size()), 64'd0);
    chk(busy == 1'b0, "R7 idle after run", 64'(busy), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule